// File: doc/BRIEF.md
# Multiplexed NOR Flash Bus Controller

This block converts single read or write requests from an on-chip host into cycles on an external NOR flash bus whose address and data share pins. Every cycle begins with an address phase. In that phase a latch-enable strobe loads the upper 18 address bits into an external transparent latch. A data phase follows. It presents the low 10 address bits and moves one data byte under a read or a write strobe. One of four active-low chip selects stays low for the whole cycle. Select 3 is intended for the boot flash.

The host side uses a valid/ready handshake. The host drives `req_valid` together with the request fields and must hold them until `req_ready` is also high on a clock edge. `req_ready` is high only while the bus is idle, so one request is in flight at a time. While a cycle runs, the controller applies back-pressure by holding `req_ready` low. Completion is a single-cycle `rsp_valid` pulse. For reads, `rsp_rdata` holds the captured byte until the next read completes. The `rsp_valid` pulse cannot be stalled.

Three clock counts set the timing: latch-enable width, address-to-strobe setup and minimum strobe width. The usual values are 2, 1 and 4. A slow device holds `bus_rdy` low to stretch the strobe. The block synchronises `bus_rdy` before using it.

Top module: `nor_mux_bus_ctrl`

## Requirements
- R1: In the address phase `bus_ale` is high, `bus_ad` carries address bits 27:18, `bus_io_out` carries address bits 17:10, `bus_io_oe` is 1, and both strobes stay high.
- R2: In the data phase (setup and strobe clocks) `bus_ad` carries address bits 9:0. For a write, `bus_io_oe` is 1 and `bus_io_out` equals the write byte. For a read, `bus_io_oe` is 0.
- R3: `bus_rd_n` goes low only in the data phase of a read, and `bus_wr_n` only in the data phase of a write. The two are never low together.
- R4: For a request with index `req_cs` = i, only bit i of `bus_cs_n` is low, from the first address-phase clock through the last strobe clock. All four bits are high when the bus is idle.
- R5: The latch-enable pulse lasts `cfg_ale_clks` clocks. The address-to-strobe setup lasts `cfg_setup_clks` clocks. The strobe lasts at least `cfg_strobe_clks` clocks. A count of 0 behaves as 1.
- R6: `bus_rdy` passes through two flops. The minimum strobe width always completes. After that, the strobe ends only on a clock where the synchronised ready is high. If `bus_rdy` rises during strobe clock K (K at least the minimum), the strobe lasts K+2 clocks. If ready recovers early, the width stays at the minimum.
- R7: Read data is sampled from `bus_io_in` on the edge where the strobe ends. `rsp_valid` is high for exactly one clock, the first clock after the strobe ends, and `rsp_rdata` then holds the sampled byte.
- R8: `req_ready` is 1 only while idle, including the clock that carries `rsp_valid`. A request is taken when `req_valid` and `req_ready` are both 1 on an edge. A request accepted while idle starts its address phase on the next clock.
- R9: When a write follows a read, one extra idle clock is inserted before the write's address phase. After a write, a following request of either kind gets no extra clock.
- R10: After reset all selects and strobes are high, `bus_ale` and `bus_io_oe` are 0, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ale_clks | input | 4 | Latch-enable width in clocks (0 acts as 1) |
| cfg_setup_clks | input | 4 | Address-to-strobe setup in clocks (0 acts as 1) |
| cfg_strobe_clks | input | 4 | Minimum strobe width in clocks (0 acts as 1) |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Chip-select index (3 = boot flash) |
| req_addr | input | 28 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Last read byte |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ale | output | 1 | Address latch enable |
| bus_ad | output | 10 | High address in address phase, low address in data phase |
| bus_io_out | output | 8 | Shared address/data lines, driven value |
| bus_io_oe | output | 1 | Output enable for the shared lines |
| bus_io_in | input | 8 | Shared address/data lines, sampled value |
| bus_rdy | input | 1 | Device ready; low inserts wait states |

## Verification
The main function is tried with reads and writes to different selects and addresses. Each address has distinct high, middle and low fields, so a swapped or misplaced field shows up on the pins. Timing settings of 2/1/4, 3/2/1 and 0/0/0 separate each phase counter and the zero-as-one rule. Two ready patterns are used. A release deep into the strobe shows the synchroniser latency. A release that comes early shows that the minimum width is still kept. Read-write, write-write and write-read orderings, issued back to back, show that the turnaround clock appears only where a write follows a read.

// File: rtl/nmb_pkg.sv
package nmb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_TURN   = 3'd1,
    PH_ALE    = 3'd2,
    PH_SETUP  = 3'd3,
    PH_STROBE = 3'd4,
    PH_WAIT   = 3'd5
  } phase_t;
endpackage

// File: rtl/nmb_rdy_sync.sv
module nmb_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nmb_seq.sv
module nmb_seq
  import nmb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic             cur_wr,
  input  logic             rdy_s,
  input  logic [CNT_W-1:0] cfg_ale,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_strobe,
  output phase_t           phase,
  output logic             capture,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic             last_rd;
  logic             last_clk;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign last_clk = (cnt == CNT_W'(1));
  assign capture  = ((phase == PH_STROBE) && last_clk && rdy_s) ||
                    ((phase == PH_WAIT) && rdy_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= CNT_W'(1);
      last_rd <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= capture;
      if (capture) last_rd <= !cur_wr;
      case (phase)
        PH_IDLE: if (start) begin
          phase <= (last_rd && start_wr) ? PH_TURN : PH_ALE;
          cnt   <= at_least_one(cfg_ale);
        end
        PH_TURN: begin
          phase <= PH_ALE;
          cnt   <= at_least_one(cfg_ale);
        end
        PH_ALE: begin
          if (last_clk) begin
            phase <= PH_SETUP;
            cnt   <= at_least_one(cfg_setup);
          end else cnt <= cnt - CNT_W'(1);
        end
        PH_SETUP: begin
          if (last_clk) begin
            phase <= PH_STROBE;
            cnt   <= at_least_one(cfg_strobe);
          end else cnt <= cnt - CNT_W'(1);
        end
        PH_STROBE: begin
          if (last_clk) phase <= rdy_s ? PH_IDLE : PH_WAIT;
          else          cnt   <= cnt - CNT_W'(1);
        end
        PH_WAIT: if (rdy_s) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_STROBE_ENDS_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_STROBE || phase == PH_WAIT) && !rdy_s) |=> (phase != PH_IDLE)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_TURN_ONLY_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN) |-> cur_wr); // R9
endmodule

// File: rtl/nmb_datapath.sv
module nmb_datapath
  import nmb_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int AD_W   = 10,
  parameter int IO_W   = 8,
  parameter int NCS    = 4,
  localparam int CSI_W = $clog2(NCS),
  localparam int HI_W  = ADDR_W - AD_W - IO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_wr,
  input  logic [CSI_W-1:0]  in_cs,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [IO_W-1:0]   in_wdata,
  input  phase_t            phase,
  input  logic              capture,
  input  logic [IO_W-1:0]   io_in,
  output logic              cur_wr,
  output logic [NCS-1:0]    cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ale,
  output logic [AD_W-1:0]   ad,
  output logic [IO_W-1:0]   io_out,
  output logic              io_oe,
  output logic [IO_W-1:0]   rdata
);
  logic [CSI_W-1:0]  cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IO_W-1:0]   wdata_q;
  logic              active, strobe, in_addr_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_wr  <= 1'b0;
      cs_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      if (load) begin
        cur_wr  <= in_wr;
        cs_q    <= in_cs;
        addr_q  <= in_addr;
        wdata_q <= in_wdata;
      end
      if (capture && !cur_wr) rdata <= io_in;
    end
  end

  assign in_addr_ph = (phase == PH_ALE);
  assign strobe     = (phase == PH_STROBE) || (phase == PH_WAIT);
  assign active     = in_addr_ph || (phase == PH_SETUP) || strobe;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = !(active && (cs_q == CSI_W'(i)));
  end

  assign ale    = in_addr_ph;
  assign rd_n   = !(strobe && !cur_wr);
  assign wr_n   = !(strobe && cur_wr);
  assign ad     = in_addr_ph ? AD_W'(addr_q[ADDR_W-1 -: HI_W]) :
                  active     ? addr_q[AD_W-1:0] : '0;
  assign io_out = in_addr_ph          ? addr_q[AD_W+IO_W-1:AD_W] :
                  (active && cur_wr)  ? wdata_q : '0;
  assign io_oe  = in_addr_ph || (active && cur_wr);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1); // R4
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R3
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && io_oe)); // R1
  AST_READ_RELEASES_IO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !io_oe); // R2
endmodule

// File: rtl/nor_mux_bus_ctrl.sv
module nor_mux_bus_ctrl
  import nmb_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int AD_W   = 10,
  parameter int IO_W   = 8,
  parameter int NCS    = 4,
  parameter int CNT_W  = 4,
  localparam int CSI_W = $clog2(NCS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_ale_clks,
  input  logic [CNT_W-1:0]  cfg_setup_clks,
  input  logic [CNT_W-1:0]  cfg_strobe_clks,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CSI_W-1:0]  req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [IO_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [IO_W-1:0]   rsp_rdata,
  output logic [NCS-1:0]    bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_ale,
  output logic [AD_W-1:0]   bus_ad,
  output logic [IO_W-1:0]   bus_io_out,
  output logic              bus_io_oe,
  input  logic [IO_W-1:0]   bus_io_in,
  input  logic              bus_rdy
);
  phase_t phase;
  logic   rdy_s, start, capture, cur_wr;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  nmb_rdy_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_rdy), .q(rdy_s)
  );

  nmb_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(req_write),
    .cur_wr(cur_wr), .rdy_s(rdy_s), .cfg_ale(cfg_ale_clks),
    .cfg_setup(cfg_setup_clks), .cfg_strobe(cfg_strobe_clks),
    .phase(phase), .capture(capture), .done(rsp_valid)
  );

  nmb_datapath #(.ADDR_W(ADDR_W), .AD_W(AD_W), .IO_W(IO_W), .NCS(NCS)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(start), .in_wr(req_write),
    .in_cs(req_cs), .in_addr(req_addr), .in_wdata(req_wdata),
    .phase(phase), .capture(capture), .io_in(bus_io_in),
    .cur_wr(cur_wr), .cs_n(bus_cs_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
    .ale(bus_ale), .ad(bus_ad), .io_out(bus_io_out), .io_oe(bus_io_oe),
    .rdata(rsp_rdata)
  );

  AST_READY_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n == '1 && bus_rd_n && bus_wr_n)); // R8
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && bus_rd_n && bus_wr_n)); // R7
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_ready); // R8
endmodule

// File: tb/nor_mux_bus_ctrl_tb.sv
module nor_mux_bus_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  cfg_ale_clks = 4'd2, cfg_setup_clks = 4'd1, cfg_strobe_clks = 4'd4;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_cs = 0;
  logic [27:0] req_addr = 0;
  logic [7:0]  req_wdata = 0;
  logic        req_ready, rsp_valid, bus_rd_n, bus_wr_n, bus_ale, bus_io_oe;
  logic [7:0]  rsp_rdata, bus_io_out, bus_io_in;
  logic [3:0]  bus_cs_n;
  logic [9:0]  bus_ad;
  logic        bus_rdy = 1;
  logic [7:0]  dev_data = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign bus_io_in = !bus_rd_n ? dev_data : 8'h00;

  nor_mux_bus_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [1:0] cs, input logic [27:0] a,
                      input logic [7:0] wd, input logic [7:0] dd, input int hold_k,
                      output int lead, output int aw, output int sw, output int tw,
                      output logic [7:0] rd);
    bit ap_ok = 1, dp_ok = 1, cs_ok = 1, sb_ok = 1, bsy_ok = 1;
    lead = 0; aw = 0; sw = 0; tw = 0;
    dev_data = dd; bus_rdy = (hold_k == 0);
    req_valid = 1; req_write = wr; req_cs = cs; req_addr = a; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_addr = 28'h0; req_wdata = 8'h0;
    while (!rsp_valid) begin
      if (bus_ale) begin
        aw++;
        if (bus_ad != a[27:18] || bus_io_out != a[17:10] || !bus_io_oe ||
            !bus_rd_n || !bus_wr_n) ap_ok = 0;
      end else if (!bus_rd_n || !bus_wr_n) begin
        tw++;
        if (bus_ad != a[9:0] || bus_io_oe != wr || (wr && bus_io_out != wd)) dp_ok = 0;
        if (hold_k != 0 && tw == hold_k) bus_rdy = 1;
      end else if (bus_cs_n != 4'hF) begin
        sw++;
        if (bus_ad != a[9:0] || bus_io_oe != wr || (wr && bus_io_out != wd)) dp_ok = 0;
      end else lead++;
      if (bus_cs_n != 4'hF) begin
        if (bus_cs_n != ~(4'b1 << cs)) cs_ok = 0;
        if (req_ready) bsy_ok = 0;
      end
      if (wr ? !bus_rd_n : !bus_wr_n) sb_ok = 0;
      if (aw + tw + sw + lead > 100) break;
      @(negedge clk);
    end
    rd = rsp_rdata;
    chk(ap_ok, "R1 address phase content", ap_ok, 1);
    chk(dp_ok, "R2 data phase content", dp_ok, 1);
    chk(sb_ok, "R3 strobe matches direction", sb_ok, 1);
    chk(cs_ok, "R4 single select", cs_ok, 1);
    chk(bsy_ok && req_ready && bus_cs_n == 4'hF, "R8 ready only when idle", req_ready, 1);
    bus_rdy = 1;
  endtask

  task automatic t_reset;
    chk(bus_cs_n == 4'hF && bus_rd_n && bus_wr_n, "R10 reset selects/strobes",
        {bus_cs_n, bus_rd_n, bus_wr_n}, 6'h3F);
    chk(!bus_ale && !bus_io_oe && !rsp_valid && req_ready, "R10 reset ale/oe/rsp/ready",
        {bus_ale, bus_io_oe, rsp_valid, req_ready}, 4'b0001);
  endtask

  task automatic t_default_write;
    int l, a, s, t; logic [7:0] r;
    cfg_ale_clks = 2; cfg_setup_clks = 1; cfg_strobe_clks = 4;
    xfer(1, 2'd1, 28'hA5C_3E7B, 8'h3C, 8'h00, 0, l, a, s, t, r);
    chk(a == 2, "R5 ale width default", a, 2);
    chk(s == 1, "R5 setup default", s, 1);
    chk(t == 4, "R5 strobe default", t, 4);
    chk(l == 0, "R8 address phase next clock", l, 0);
  endtask

  task automatic t_read_boot;
    int l, a, s, t; logic [7:0] r;
    xfer(0, 2'd3, 28'h3FF_C001, 8'h00, 8'h96, 0, l, a, s, t, r);
    chk(r == 8'h96, "R7 read data captured", r, 8'h96);
    chk(t == 4, "R5 read strobe width", t, 4);
    @(negedge clk);
    chk(!rsp_valid, "R7 done single clock", rsp_valid, 0);
    chk(rsp_rdata == 8'h96, "R7 read data held", rsp_rdata, 8'h96);
  endtask

  task automatic t_other_timing;
    int l, a, s, t; logic [7:0] r;
    cfg_ale_clks = 3; cfg_setup_clks = 2; cfg_strobe_clks = 1;
    xfer(1, 2'd0, 28'h155_AA55, 8'hC3, 8'h00, 0, l, a, s, t, r);
    chk(a == 3 && s == 2 && t == 1, "R5 timing 3/2/1", {a[3:0], s[3:0], t[3:0]}, 12'h321);
    cfg_ale_clks = 0; cfg_setup_clks = 0; cfg_strobe_clks = 0;
    xfer(0, 2'd2, 28'h0AB_CDEF, 8'h00, 8'h5A, 0, l, a, s, t, r);
    chk(a == 1 && s == 1 && t == 1, "R5 zero acts as one", {a[3:0], s[3:0], t[3:0]}, 12'h111);
    chk(r == 8'h5A, "R7 read data short strobe", r, 8'h5A);
    cfg_ale_clks = 2; cfg_setup_clks = 1; cfg_strobe_clks = 4;
  endtask

  task automatic t_wait_states;
    int l, a, s, t; logic [7:0] r;
    xfer(0, 2'd1, 28'h210_0321, 8'h00, 8'h71, 6, l, a, s, t, r);
    chk(t == 8, "R6 wait extends strobe", t, 8);
    chk(r == 8'h71, "R7 read after wait", r, 8'h71);
    xfer(1, 2'd1, 28'h210_0322, 8'h18, 8'h00, 1, l, a, s, t, r);
    chk(t == 4, "R6 minimum width kept", t, 4);
  endtask

  task automatic t_turnaround;
    int l, a, s, t; logic [7:0] r;
    xfer(0, 2'd0, 28'h001_0203, 8'h00, 8'h44, 0, l, a, s, t, r);
    xfer(1, 2'd0, 28'h001_0204, 8'h45, 8'h00, 0, l, a, s, t, r);
    chk(l == 1, "R9 read then write idle clock", l, 1);
    xfer(1, 2'd0, 28'h001_0205, 8'h46, 8'h00, 0, l, a, s, t, r);
    chk(l == 0, "R9 write then write no gap", l, 0);
    xfer(0, 2'd0, 28'h001_0206, 8'h00, 8'h47, 0, l, a, s, t, r);
    chk(l == 0, "R9 write then read no gap", l, 0);
    chk(r == 8'h47, "R7 back-to-back read data", r, 8'h47);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_default_write();
    @(negedge clk);
    t_read_boot();
    t_other_timing();
    @(negedge clk);
    t_wait_states();
    @(negedge clk);
    t_turnaround();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule